// File: doc/BRIEF.md
# Device Error Signaling Filter

This block takes one detected error per strobe and decides what the device does with it. It works out which device-status detect bits, correctable-status bits and uncorrectable-status bits to set. It also decides whether the error header must be logged and whether an error message goes upstream, and at which severity. The error arrives as a one-hot status vector. The block weighs it against the mask and severity registers, the device-control reporting enables and the command-register SERR enable.

An uncorrectable error that would be non-fatal can be flagged as possibly advisory. Such an error is handled through the correctable path under a dedicated advisory bit, and each class has its own gating rules.

A second, independent path serves switch and root ports. It filters error messages that arrive from downstream through the bridge SERR enable and the same reporting enables. It returns the secondary and primary status set pulses and a forwarded message.

All results are registered and appear as one-cycle pulses on the clock edge after the strobe.

Top module: `err_signal_filter`

## Requirements
- R1: A correctable error (err_cor=1) sets cor-detected (dsta_set bit 0) and its own bit in cor_sta_set. When that bit is set in cor_mask, no message is sent. Otherwise a message of severity correctable is sent if rep_en_cor is 1.
- R2: An uncorrectable error sets fatal-detected (dsta_set bit 2) or non-fatal-detected (bit 1), and always sets its bit in unc_sta_set. When its unc_mask bit is 1, there is no log request and no message. Otherwise log_req is raised.
- R3: With USE_SEV_REG=1 an uncorrectable error is fatal when its unc_sev bit is 1. With USE_SEV_REG=0 the fixed default applies: bits 4, 5, 13, 17, 18 and 22 are fatal and every other bit is non-fatal.
- R4: A non-fatal uncorrectable error with err_adv_ok=1 takes the correctable path. It sets dsta_set bit 0 (not bit 1) and cor_sta_set bit ADV_BIT (13). When cor_mask bit 13 is clear, its unc_sta_set bit is also set, log_req follows its unc_mask bit being clear, and a correctable message follows R1 and R5. When cor_mask bit 13 is set, neither the unc_sta_set bit nor log_req is produced.
- R5: Uncorrectable bit UR_BIT (20) is an unsupported request and also sets dsta_set bit 3. On the correctable (advisory) path its message additionally needs rep_en_ur. On the uncorrectable path its message needs rep_en_ur or serr_en.
- R6: A fatal message needs serr_en or rep_en_fatal. A non-fatal message needs serr_en or rep_en_nf. msg_sev / fwd_sev is one-hot: bit 0 correctable, bit 1 non-fatal, bit 2 fatal.
- R7: If the error vector, ANDed with the supported set of its class (COR_SUP or UNC_SUP), does not hold exactly one bit, the strobe produces no output at all.
- R8: All outputs are zero after reset. They are driven on the clock edge that samples the strobe and last exactly one cycle.
- R9: A downstream message with dn_sev non-fatal or fatal pulses sec_rse_set whatever bridge_serr_en is. No message is forwarded while bridge_serr_en is 0.
- R10: With bridge_serr_en=1, sig_se_set pulses when (the message is uncorrectable and serr_en=1) or the enable for its own severity is 1. fwd_valid pulses with fwd_sev=dn_sev only when the severity's own enable is 1.
- R11: A downstream message whose dn_sev is not one-hot is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 1 | Strobe: one detected error this cycle |
| err_vec | input | 32 | One-hot error status bit |
| err_cor | input | 1 | Error belongs to the correctable class |
| err_adv_ok | input | 1 | Non-fatal error may be treated as advisory |
| cor_mask | input | 32 | Correctable mask register |
| unc_mask | input | 32 | Uncorrectable mask register |
| unc_sev | input | 32 | Uncorrectable severity register (1 = fatal) |
| rep_en_cor | input | 1 | Correctable reporting enable |
| rep_en_nf | input | 1 | Non-fatal reporting enable |
| rep_en_fatal | input | 1 | Fatal reporting enable |
| rep_en_ur | input | 1 | Unsupported-request reporting enable |
| serr_en | input | 1 | Command register SERR enable |
| dn_valid | input | 1 | Message arriving from downstream |
| dn_sev | input | 3 | Severity of the arriving message, one-hot |
| bridge_serr_en | input | 1 | Bridge control SERR enable |
| dsta_set | output | 4 | Device status set: bit0 cor, bit1 non-fatal, bit2 fatal, bit3 UR |
| cor_sta_set | output | 32 | Correctable status set pulse |
| unc_sta_set | output | 32 | Uncorrectable status set pulse |
| log_req | output | 1 | Request to log the error header |
| msg_valid | output | 1 | Own error message emitted |
| msg_sev | output | 3 | Severity of the own message |
| sec_rse_set | output | 1 | Secondary status received-system-error set |
| sig_se_set | output | 1 | Primary status signaled-system-error set |
| fwd_valid | output | 1 | Downstream message forwarded upstream |
| fwd_sev | output | 3 | Severity of the forwarded message |

## Verification
On every cycle the assertions confirm several invariants. The block stays silent in the cycle after a cycle with no strobe. Message severities are one-hot and agree with the detect bits. A log request always comes with exactly one uncorrectable status bit. A forwarded message implies both a signaled system error and an enabled bridge. The remaining behaviours depend on the values of particular mask, severity and enable bits, so only the bench scenarios can show them. These are the advisory conversion and its cor-mask dependency, the default severity table, unsupported-request gating, the rejection of bad vectors, and SERR-only paths that signal without forwarding.

// File: rtl/esf_pkg.sv
package esf_pkg;

    localparam int ERR_W = 32;

    typedef logic [ERR_W-1:0] errvec_t;

    typedef enum logic [2:0] {
        SEV_NONE  = 3'b000,
        SEV_COR   = 3'b001,
        SEV_NF    = 3'b010,
        SEV_FATAL = 3'b100
    } sev_e;

    // device status set bits, bit 0 = cor
    typedef struct packed {
        logic ur;
        logic fatal;
        logic nonfatal;
        logic cor;
    } dsta_t;

    // classification of one strobe
    typedef struct packed {
        logic    ok;
        logic    cor_path;
        logic    adv;
        logic    ur;
        logic    fatal;
        errvec_t bitv;
    } cls_t;

    // actions for one error
    typedef struct packed {
        dsta_t   dsta;
        errvec_t cor_set;
        errvec_t unc_set;
        logic    log_req;
        logic    msg_v;
        sev_e    msg_sev;
    } act_t;

    // actions for one downstream message
    typedef struct packed {
        logic sec_rse;
        logic sig_se;
        logic fwd_v;
        sev_e fwd_sev;
    } fwd_t;

    function automatic logic single_bit(input errvec_t v);
        return ($countones(v) == 1);
    endfunction

    function automatic logic sev_onehot(input logic [2:0] s);
        return ($countones(s) == 1);
    endfunction

endpackage

// File: rtl/esf_classify.sv
module esf_classify
    import esf_pkg::*;
#(
    parameter int      UR_BIT      = 20,
    parameter errvec_t COR_SUP     = 32'h0000_F1C1,
    parameter errvec_t UNC_SUP     = 32'h03FF_F030,
    parameter errvec_t DFLT_FATAL  = 32'h0046_2030,
    parameter bit      USE_SEV_REG = 1'b1
) (
    input  errvec_t err_vec,
    input  logic    err_cor,
    input  logic    err_adv_ok,
    input  errvec_t unc_sev,
    output cls_t    cls
);

    errvec_t kept;
    logic    sev_hit;

    assign kept = err_cor ? (err_vec & COR_SUP) : (err_vec & UNC_SUP);

    generate
        if (USE_SEV_REG) begin : g_sev_reg
            assign sev_hit = |(kept & unc_sev);
        end else begin : g_sev_fixed
            assign sev_hit = |(kept & DFLT_FATAL);
        end
    endgenerate

    always_comb begin
        cls          = '0;
        cls.ok       = single_bit(kept);
        cls.bitv     = kept;
        cls.fatal    = !err_cor && sev_hit;
        cls.adv      = !err_cor && !sev_hit && err_adv_ok;
        cls.cor_path = err_cor || cls.adv;
        cls.ur       = !err_cor && kept[UR_BIT];
    end

endmodule

// File: rtl/esf_gate.sv
module esf_gate
    import esf_pkg::*;
#(
    parameter int ADV_BIT = 13
) (
    input  cls_t    cls,
    input  errvec_t cor_mask,
    input  errvec_t unc_mask,
    input  logic    en_cor,
    input  logic    en_nf,
    input  logic    en_fatal,
    input  logic    en_ur,
    input  logic    serr_en,
    output act_t    act
);

    localparam errvec_t ADV_VEC = errvec_t'(1) << ADV_BIT;

    errvec_t cor_bit;
    logic    cor_masked;
    logic    unc_masked;

    always_comb begin
        cor_bit = cls.adv ? ADV_VEC : cls.bitv;
    end

    assign cor_masked = |(cor_bit & cor_mask);
    assign unc_masked = |(cls.bitv & unc_mask);

    always_comb begin
        act = '0;
        if (cls.ok) begin
            act.dsta.ur = cls.ur;
            if (cls.cor_path) begin
                act.dsta.cor = 1'b1;
                act.cor_set  = cor_bit;
                if (!cor_masked) begin
                    if (cls.adv) begin
                        act.unc_set = cls.bitv;
                        act.log_req = !unc_masked;
                    end
                    if (en_cor && (!cls.ur || en_ur)) begin
                        act.msg_v   = 1'b1;
                        act.msg_sev = SEV_COR;
                    end
                end
            end else begin
                act.dsta.fatal    = cls.fatal;
                act.dsta.nonfatal = !cls.fatal;
                act.unc_set       = cls.bitv;
                if (!unc_masked) begin
                    act.log_req = 1'b1;
                    if ((!cls.ur || en_ur || serr_en) &&
                        (serr_en || (cls.fatal ? en_fatal : en_nf))) begin
                        act.msg_v   = 1'b1;
                        act.msg_sev = cls.fatal ? SEV_FATAL : SEV_NF;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/esf_bridge_fwd.sv
module esf_bridge_fwd
    import esf_pkg::*;
(
    input  logic       dn_valid,
    input  logic [2:0] dn_sev,
    input  logic       bridge_serr_en,
    input  logic       en_cor,
    input  logic       en_nf,
    input  logic       en_fatal,
    input  logic       serr_en,
    output fwd_t       fwd
);

    logic uncor;
    logic own_en;

    assign uncor  = dn_sev[1] | dn_sev[2];
    assign own_en = |(dn_sev & {en_fatal, en_nf, en_cor});

    always_comb begin
        fwd = '0;
        if (dn_valid && sev_onehot(dn_sev)) begin
            fwd.sec_rse = uncor;
            if (bridge_serr_en) begin
                fwd.sig_se = (uncor && serr_en) || own_en;
                if (own_en) begin
                    fwd.fwd_v   = 1'b1;
                    fwd.fwd_sev = sev_e'(dn_sev);
                end
            end
        end
    end

endmodule

// File: rtl/err_signal_filter.sv
module err_signal_filter
    import esf_pkg::*;
#(
    parameter int      UR_BIT      = 20,
    parameter int      ADV_BIT     = 13,
    parameter errvec_t COR_SUP     = 32'h0000_F1C1,
    parameter errvec_t UNC_SUP     = 32'h03FF_F030,
    parameter errvec_t DFLT_FATAL  = 32'h0046_2030,
    parameter bit      USE_SEV_REG = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      err_valid,
    input  logic [esf_pkg::ERR_W-1:0] err_vec,
    input  logic                      err_cor,
    input  logic                      err_adv_ok,
    input  logic [esf_pkg::ERR_W-1:0] cor_mask,
    input  logic [esf_pkg::ERR_W-1:0] unc_mask,
    input  logic [esf_pkg::ERR_W-1:0] unc_sev,
    input  logic                      rep_en_cor,
    input  logic                      rep_en_nf,
    input  logic                      rep_en_fatal,
    input  logic                      rep_en_ur,
    input  logic                      serr_en,
    input  logic                      dn_valid,
    input  logic [2:0]                dn_sev,
    input  logic                      bridge_serr_en,
    output logic [3:0]                dsta_set,
    output logic [esf_pkg::ERR_W-1:0] cor_sta_set,
    output logic [esf_pkg::ERR_W-1:0] unc_sta_set,
    output logic                      log_req,
    output logic                      msg_valid,
    output logic [2:0]                msg_sev,
    output logic                      sec_rse_set,
    output logic                      sig_se_set,
    output logic                      fwd_valid,
    output logic [2:0]                fwd_sev
);

    cls_t cls;
    act_t act_d, act_q;
    fwd_t fwd_d, fwd_q;

    esf_classify #(
        .UR_BIT     (UR_BIT),
        .COR_SUP    (COR_SUP),
        .UNC_SUP    (UNC_SUP),
        .DFLT_FATAL (DFLT_FATAL),
        .USE_SEV_REG(USE_SEV_REG)
    ) u_cls (
        .err_vec   (err_vec),
        .err_cor   (err_cor),
        .err_adv_ok(err_adv_ok),
        .unc_sev   (unc_sev),
        .cls       (cls)
    );

    esf_gate #(
        .ADV_BIT(ADV_BIT)
    ) u_gate (
        .cls     (cls),
        .cor_mask(cor_mask),
        .unc_mask(unc_mask),
        .en_cor  (rep_en_cor),
        .en_nf   (rep_en_nf),
        .en_fatal(rep_en_fatal),
        .en_ur   (rep_en_ur),
        .serr_en (serr_en),
        .act     (act_d)
    );

    esf_bridge_fwd u_fwd (
        .dn_valid      (dn_valid),
        .dn_sev        (dn_sev),
        .bridge_serr_en(bridge_serr_en),
        .en_cor        (rep_en_cor),
        .en_nf         (rep_en_nf),
        .en_fatal      (rep_en_fatal),
        .serr_en       (serr_en),
        .fwd           (fwd_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            fwd_q <= '0;
        end else begin
            act_q <= err_valid ? act_d : '0;
            fwd_q <= fwd_d;
        end
    end

    assign dsta_set    = act_q.dsta;
    assign cor_sta_set = act_q.cor_set;
    assign unc_sta_set = act_q.unc_set;
    assign log_req     = act_q.log_req;
    assign msg_valid   = act_q.msg_v;
    assign msg_sev     = act_q.msg_sev;
    assign sec_rse_set = fwd_q.sec_rse;
    assign sig_se_set  = fwd_q.sig_se;
    assign fwd_valid   = fwd_q.fwd_v;
    assign fwd_sev     = fwd_q.fwd_sev;

endmodule

// File: rtl/esf_chk.sv
module esf_chk (
    input logic        clk,
    input logic        rst,
    input logic        err_valid,
    input logic        dn_valid,
    input logic        bridge_serr_en,
    input logic [3:0]  dsta_set,
    input logic [31:0] unc_sta_set,
    input logic        log_req,
    input logic        msg_valid,
    input logic [2:0]  msg_sev,
    input logic        sec_rse_set,
    input logic        sig_se_set,
    input logic        fwd_valid
);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(err_valid) |-> (dsta_set == 4'b0) && !log_req && !msg_valid);

    // R11
    dn_idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(dn_valid) |-> !fwd_valid && !sec_rse_set && !sig_se_set);

    // R6
    msg_sev_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> ($countones(msg_sev) == 1));

    // R2
    log_has_status_chk: assert property (@(posedge clk) disable iff (rst)
        log_req |-> ($countones(unc_sta_set) == 1));

    // R1
    cor_msg_detect_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_sev == 3'b001) |-> dsta_set[0]);

    // R6
    fatal_msg_detect_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_sev == 3'b100) |-> dsta_set[2]);

    // R10
    fwd_signals_chk: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> sig_se_set);

    // R9
    fwd_needs_bridge_chk: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> $past(bridge_serr_en));

endmodule

bind err_signal_filter esf_chk u_esf_chk (
    .clk           (clk),
    .rst           (rst),
    .err_valid     (err_valid),
    .dn_valid      (dn_valid),
    .bridge_serr_en(bridge_serr_en),
    .dsta_set      (dsta_set),
    .unc_sta_set   (unc_sta_set),
    .log_req       (log_req),
    .msg_valid     (msg_valid),
    .msg_sev       (msg_sev),
    .sec_rse_set   (sec_rse_set),
    .sig_se_set    (sig_se_set),
    .fwd_valid     (fwd_valid)
);

// File: tb/tb_err_signal_filter.sv
module tb_err_signal_filter;
    import esf_pkg::*;

    localparam logic [31:0] T_COR_SUP = 32'h0000_F1C1;
    localparam logic [31:0] T_UNC_SUP = 32'h03FF_F030;
    localparam logic [31:0] T_FATAL   = 32'h0046_2030;

    logic clk = 1'b0;
    logic rst;
    always #5 clk = ~clk;

    logic        err_valid, err_cor, err_adv_ok;
    logic [31:0] err_vec, cor_mask, unc_mask, unc_sev;
    logic        rep_en_cor, rep_en_nf, rep_en_fatal, rep_en_ur, serr_en;
    logic        dn_valid, bridge_serr_en;
    logic [2:0]  dn_sev;

    logic [3:0]  dsta_set, d_dsta_set;
    logic [31:0] cor_sta_set, unc_sta_set, d_cor_sta_set, d_unc_sta_set;
    logic        log_req, msg_valid, d_log_req, d_msg_valid;
    logic [2:0]  msg_sev, fwd_sev, d_msg_sev, d_fwd_sev;
    logic        sec_rse_set, sig_se_set, fwd_valid;
    logic        d_sec_rse_set, d_sig_se_set, d_fwd_valid;

    err_signal_filter dut (
        .clk(clk), .rst(rst), .err_valid(err_valid), .err_vec(err_vec),
        .err_cor(err_cor), .err_adv_ok(err_adv_ok), .cor_mask(cor_mask),
        .unc_mask(unc_mask), .unc_sev(unc_sev), .rep_en_cor(rep_en_cor),
        .rep_en_nf(rep_en_nf), .rep_en_fatal(rep_en_fatal), .rep_en_ur(rep_en_ur),
        .serr_en(serr_en), .dn_valid(dn_valid), .dn_sev(dn_sev),
        .bridge_serr_en(bridge_serr_en), .dsta_set(dsta_set),
        .cor_sta_set(cor_sta_set), .unc_sta_set(unc_sta_set), .log_req(log_req),
        .msg_valid(msg_valid), .msg_sev(msg_sev), .sec_rse_set(sec_rse_set),
        .sig_se_set(sig_se_set), .fwd_valid(fwd_valid), .fwd_sev(fwd_sev)
    );

    err_signal_filter #(.USE_SEV_REG(1'b0)) dut_d (
        .clk(clk), .rst(rst), .err_valid(err_valid), .err_vec(err_vec),
        .err_cor(err_cor), .err_adv_ok(err_adv_ok), .cor_mask(cor_mask),
        .unc_mask(unc_mask), .unc_sev(unc_sev), .rep_en_cor(rep_en_cor),
        .rep_en_nf(rep_en_nf), .rep_en_fatal(rep_en_fatal), .rep_en_ur(rep_en_ur),
        .serr_en(serr_en), .dn_valid(dn_valid), .dn_sev(dn_sev),
        .bridge_serr_en(bridge_serr_en), .dsta_set(d_dsta_set),
        .cor_sta_set(d_cor_sta_set), .unc_sta_set(d_unc_sta_set), .log_req(d_log_req),
        .msg_valid(d_msg_valid), .msg_sev(d_msg_sev), .sec_rse_set(d_sec_rse_set),
        .sig_se_set(d_sig_se_set), .fwd_valid(d_fwd_valid), .fwd_sev(d_fwd_sev)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // expected actions for one error, written from the requirements
    function automatic act_t ref_act(input logic use_reg);
        act_t r;
        logic [31:0] s;
        logic fat, ur;
        r = '0;
        if (!err_valid) return r;
        s = err_vec & (err_cor ? T_COR_SUP : T_UNC_SUP);
        if ($countones(s) != 1) return r;
        if (err_cor) begin
            r.dsta.cor = 1'b1;
            r.cor_set  = s;
            if ((s & cor_mask) == 0 && rep_en_cor) begin
                r.msg_v = 1'b1; r.msg_sev = SEV_COR;
            end
            return r;
        end
        fat = use_reg ? ((s & unc_sev) != 0) : ((s & T_FATAL) != 0);
        ur  = s[20];
        r.dsta.ur = ur;
        if (!fat && err_adv_ok) begin
            r.dsta.cor = 1'b1;
            r.cor_set  = 32'h0000_2000;
            if (!cor_mask[13]) begin
                r.unc_set = s;
                r.log_req = ((s & unc_mask) == 0);
                if (rep_en_cor && (!ur || rep_en_ur)) begin
                    r.msg_v = 1'b1; r.msg_sev = SEV_COR;
                end
            end
            return r;
        end
        r.dsta.fatal    = fat;
        r.dsta.nonfatal = !fat;
        r.unc_set       = s;
        if ((s & unc_mask) != 0) return r;
        r.log_req = 1'b1;
        if (ur && !rep_en_ur && !serr_en) return r;
        if (serr_en || (fat ? rep_en_fatal : rep_en_nf)) begin
            r.msg_v = 1'b1; r.msg_sev = fat ? SEV_FATAL : SEV_NF;
        end
        return r;
    endfunction

    function automatic fwd_t ref_fwd();
        fwd_t r;
        logic unc, own;
        r = '0;
        if (!dn_valid || $countones(dn_sev) != 1) return r;
        unc = (dn_sev != 3'b001);
        r.sec_rse = unc;
        if (!bridge_serr_en) return r;
        own = (dn_sev == 3'b001 && rep_en_cor) || (dn_sev == 3'b010 && rep_en_nf) ||
              (dn_sev == 3'b100 && rep_en_fatal);
        r.sig_se = (unc && serr_en) || own;
        if (own) begin
            r.fwd_v = 1'b1; r.fwd_sev = sev_e'(dn_sev);
        end
        return r;
    endfunction

    // apply current inputs for one cycle and compare both instances
    task automatic fire(input string tag);
        act_t ea, ead;
        fwd_t ef;
        ea  = ref_act(1'b1);
        ead = ref_act(1'b0);
        ef  = ref_fwd();
        @(negedge clk);
        chk({tag, " dsta"},  {60'd0, dsta_set},    {60'd0, ea.dsta});
        chk({tag, " corst"}, {32'd0, cor_sta_set}, {32'd0, ea.cor_set});
        chk({tag, " uncst"}, {32'd0, unc_sta_set}, {32'd0, ea.unc_set});
        chk({tag, " msg"},   {59'd0, log_req, msg_valid, msg_sev},
                             {59'd0, ea.log_req, ea.msg_v, ea.msg_sev});
        chk({tag, " R3 fixed-sev act"},
            {d_dsta_set, d_log_req, d_msg_valid, d_msg_sev, d_unc_sta_set, 23'd0},
            {ead.dsta, ead.log_req, ead.msg_v, ead.msg_sev, ead.unc_set, 23'd0});
        chk({tag, " fwd"},   {58'd0, sec_rse_set, sig_se_set, fwd_valid, fwd_sev},
                             {58'd0, ef.sec_rse, ef.sig_se, ef.fwd_v, ef.fwd_sev});
        err_valid = 1'b0;
        dn_valid  = 1'b0;
    endtask

    task automatic set_err(input logic [31:0] v, input logic c, input logic a);
        err_vec = v; err_cor = c; err_adv_ok = a; err_valid = 1'b1;
    endtask

    task automatic set_en(input logic ec, input logic en, input logic ef,
                          input logic eu, input logic se);
        rep_en_cor = ec; rep_en_nf = en; rep_en_fatal = ef; rep_en_ur = eu; serr_en = se;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R8 watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1;
        err_valid = 0; err_vec = 0; err_cor = 0; err_adv_ok = 0;
        cor_mask = 0; unc_mask = 0; unc_sev = 0;
        set_en(0, 0, 0, 0, 0);
        dn_valid = 0; dn_sev = 0; bridge_serr_en = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        chk("R8 reset outputs",
            {dsta_set, cor_sta_set, log_req, msg_valid, fwd_valid, sig_se_set, sec_rse_set},
            '0);

        // R1 correctable bit 6, unmasked then masked
        set_en(1, 1, 1, 1, 0);
        set_err(32'h40, 1, 0); fire("R1 cor unmasked");
        chk("R1 cor msg sev", {61'd0, msg_sev}, 64'd1);
        cor_mask = 32'h40;
        set_err(32'h40, 1, 0); fire("R1 cor masked");
        chk("R1 masked no msg", {63'd0, msg_valid}, 64'd0);
        // R8 pulse falls
        @(negedge clk);
        chk("R8 pulse ends", {59'd0, dsta_set, msg_valid}, 64'd0);
        cor_mask = 0;

        // R2 non-fatal uncorrectable bit 12, unmasked then masked
        set_err(32'h1000, 0, 0); fire("R2 uncor unmasked");
        chk("R2 nf detect", {60'd0, dsta_set}, 64'h2);
        unc_mask = 32'h1000;
        set_err(32'h1000, 0, 0); fire("R2 uncor masked");
        chk("R2 masked no log", {62'd0, log_req, msg_valid}, 64'd0);
        unc_mask = 0;

        // R3 severity register vs fixed default
        unc_sev = 0;
        set_err(32'h10, 0, 0); fire("R3 bit4");
        chk("R3 reg nf", {60'd0, dsta_set}, 64'h2);
        chk("R3 fixed fatal", {60'd0, d_dsta_set}, 64'h4);
        unc_sev = 32'h1000;
        set_err(32'h1000, 0, 0); fire("R3 bit12");
        chk("R3 reg fatal", {60'd0, dsta_set}, 64'h4);
        chk("R3 fixed nf", {60'd0, d_dsta_set}, 64'h2);
        unc_sev = 0;

        // R4 advisory
        unc_mask = 32'h4000;
        set_err(32'h4000, 0, 1); fire("R4 advisory");
        chk("R4 adv cor bit", {32'd0, cor_sta_set}, 64'h2000);
        chk("R4 adv unc bit", {32'd0, unc_sta_set}, 64'h4000);
        chk("R4 adv no log", {63'd0, log_req}, 64'd0);
        unc_mask = 0;
        cor_mask = 32'h2000;
        set_err(32'h4000, 0, 1); fire("R4 advisory cor-masked");
        chk("R4 masked no unc", {31'd0, log_req, unc_sta_set}, 64'd0);
        cor_mask = 0;

        // R5 unsupported request
        set_en(1, 1, 1, 0, 0);
        set_err(32'h10_0000, 0, 0); fire("R5 ur blocked");
        chk("R5 ur no msg", {63'd0, msg_valid}, 64'd0);
        chk("R5 ur detect", {60'd0, dsta_set}, 64'hA);
        set_en(0, 0, 0, 0, 1);
        set_err(32'h10_0000, 0, 0); fire("R5 ur serr");
        chk("R5 ur serr msg", {61'd0, msg_sev}, 64'd2);
        set_en(1, 0, 0, 0, 1);
        set_err(32'h10_0000, 0, 1); fire("R5 ur advisory blocked");
        chk("R5 adv ur no msg", {63'd0, msg_valid}, 64'd0);

        // R6 fatal by SERR only
        set_en(0, 0, 0, 0, 1);
        set_err(32'h20, 0, 0); unc_sev = 32'h20; fire("R6 fatal serr");
        chk("R6 fatal sev", {61'd0, msg_sev}, 64'd4);
        unc_sev = 0;

        // R7 bad vectors
        set_en(1, 1, 1, 1, 1);
        set_err(32'h1, 0, 0); fire("R7 unsupported bit");
        chk("R7 silent", {59'd0, dsta_set, log_req}, 64'd0);
        set_err(32'h3000, 0, 0); fire("R7 two bits");
        chk("R7 silent2", {59'd0, dsta_set, log_req}, 64'd0);

        // R9 / R10 / R11 downstream
        set_en(0, 0, 0, 0, 1);
        dn_valid = 1; dn_sev = 3'b100; bridge_serr_en = 0; fire("R9 bridge off");
        chk("R9 rse no fwd", {62'd0, sec_rse_set, fwd_valid}, 64'h2);
        dn_valid = 1; dn_sev = 3'b010; bridge_serr_en = 1; fire("R10 serr only");
        chk("R10 signal no fwd", {62'd0, sig_se_set, fwd_valid}, 64'h2);
        set_en(1, 0, 0, 0, 0);
        dn_valid = 1; dn_sev = 3'b001; fire("R10 cor fwd");
        chk("R10 cor fwd", {60'd0, fwd_valid, fwd_sev}, 64'h9);
        dn_valid = 1; dn_sev = 3'b011; fire("R11 bad sev");
        chk("R11 ignored", {61'd0, sec_rse_set, sig_se_set, fwd_valid}, 64'd0);

        // random mix
        for (int i = 0; i < 1500; i++) begin
            cor_mask = $urandom & $urandom;
            unc_mask = $urandom & $urandom;
            unc_sev  = $urandom;
            set_en($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                   $urandom_range(0, 1), $urandom_range(0, 1));
            if ($urandom_range(0, 9) == 0)
                set_err($urandom, $urandom_range(0, 1), $urandom_range(0, 1));
            else
                set_err(32'h1 << $urandom_range(0, 31), $urandom_range(0, 1),
                        $urandom_range(0, 1));
            err_valid = ($urandom_range(0, 7) != 0);
            dn_valid = $urandom_range(0, 1);
            dn_sev = ($urandom_range(0, 5) == 0) ? 3'($urandom) : (3'b001 << $urandom_range(0, 2));
            bridge_serr_en = $urandom_range(0, 1);
            fire("R1 R2 R4 R6 R10 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule